// File: doc/BRIEF.md
# Shadow Stack Execution Unit

This unit carries out the shadow stack operations of a RISC-V style integer core. It holds the shadow stack pointer. It recognises the may-be-operation encodings, both the 32-bit and the compressed forms, that become shadow stack operations when shadow stacks are enabled. It also recognises the shadow stack atomic swap. Every operation finishes with a single completion record, which gives a register write-back or an exception.

A push stores a register just below the current pointer and then lowers the pointer. A pop-and-check loads the word at the pointer and compares it with a link register. It raises the pointer only when the two agree. A mismatch raises a software-check exception.

All memory traffic goes through a one-request-at-a-time load/store port. Every request on that port is tagged as a shadow stack access. A misaligned address is reported as a store access fault, and so is an error response from memory. When the enable input is low, the shadow stack encodings fall back to may-be-operations that write zero. The swap becomes illegal in that case.

The pipeline supplies two register operands with each instruction. Push data always comes from `rs2_data`, and for the compressed push the pipeline places x1 there. The link value of a pop-and-check always comes from `rs1_data`, and for the compressed pop the pipeline places x5 there.

Top module: `sstk_exec_unit`

## Requirements
- R1: After reset the pointer equals SSP_RESET (0), `busy` is 0, and neither `done_valid` nor `mem_req_valid` is asserted.
- R2: A pointer write (`ssp_wr_en`) takes effect on the next clock edge when the unit is idle. It is ignored while `busy` is 1.
- R3: Push is recognised in two forms: the 32-bit form `instr & 0xFE00707F == 0xCE004073` with rd=0, rs1=0 and rs2 equal to 1 or 5, and the compressed form `instr[15:0] == 0x6081`. It issues a store of `rs2_data` at pointer−XLEN/8 with size code log2(XLEN/8). The pointer takes the lowered value at the edge where an error-free response is accepted.
- R4: Pop-and-check is recognised in two forms: `instr & 0xFFF0707F == 0xCDC04073` with rd=0 and rs1 equal to 1 or 5, and the compressed form `0x6281`. It issues a load at the pointer. When the returned data equals `rs1_data`, the pointer rises by XLEN/8.
- R5: A pop-and-check whose loaded value differs from the link value completes with `done_exc`=1, cause 18 and tval 3, and the pointer is left unchanged.
- R6: A push, pop or swap address that is not naturally aligned to the access size completes one cycle after acceptance with cause 7 and tval equal to that address. No memory request is made.
- R7: A memory response with `mem_rsp_err`=1 completes with cause 7 and tval equal to the request address, and the pointer is left unchanged.
- R8: Read-pointer (`0xCDC04073` pattern with rs1=0 and rd≠0) writes the current pointer to rd.
- R9: Any one-source may-be-operation (`instr & 0xB3C0707F == 0x81C04073`) or two-source may-be-operation (`instr & 0xB200707F == 0x82004073`) that is not a shadow stack operation writes 0 to rd (`done_rd_we`=1 when rd≠0) and makes no memory request. This covers every shadow stack encoding while `sse_en`=0. A compressed may-be-operation (`instr[15:0] & 0xF8FF == 0x6081`) that is not a shadow stack operation writes nothing.
- R10: Swap (`instr & 0xF800707F` equal to `0x4800202F` for the word form or `0x4800302F` for the doubleword form, the latter only when XLEN=64) issues an atomic store-swap of `rs2_data` at `rs1_data` and returns the old value to rd. The word form's result is sign-extended from bit 31.
- R11: A swap while `sse_en`=0, and any unrecognised instruction, completes with cause 2, tval equal to the instruction, and no register write.
- R12: Only one memory request is outstanding. `busy` is 1 from acceptance until the response edge, and `issue_valid` is ignored while `busy` is 1.
- R13: Each memory request lasts exactly one cycle and carries `mem_req_ss_tag`=1.
- R14: Operations that do not touch memory complete one cycle after acceptance. Memory operations complete one cycle after the edge that accepts the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sse_en | input | 1 | Shadow stacks enabled for the current privilege |
| issue_valid | input | 1 | Instruction offered this cycle |
| issue_instr | input | 32 | Instruction bits (compressed in the low half when bits [1:0] are not 11) |
| rs1_data | input | XLEN | First operand: link value or swap address |
| rs2_data | input | XLEN | Second operand: push or swap data |
| busy | output | 1 | Memory operation in flight |
| ssp_wr_en | input | 1 | Pointer register write strobe |
| ssp_wr_data | input | XLEN | Pointer register write value |
| ssp_value | output | XLEN | Current shadow stack pointer |
| mem_req_valid | output | 1 | Memory request, one-cycle pulse |
| mem_req_write | output | 1 | 1 for a store or swap, 0 for a load |
| mem_req_swap | output | 1 | Atomic swap request |
| mem_req_size | output | 2 | log2 of the access size in bytes |
| mem_req_ss_tag | output | 1 | Shadow stack access tag |
| mem_req_addr | output | XLEN | Request address |
| mem_req_wdata | output | XLEN | Store or swap data |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_err | input | 1 | Response carries an access error |
| mem_rsp_rdata | input | XLEN | Load data or old swap value |
| done_valid | output | 1 | Completion record valid, one-cycle pulse |
| done_rd_we | output | 1 | Write rd |
| done_rd_idx | output | 5 | Destination register index |
| done_rd_data | output | XLEN | Write-back value |
| done_exc | output | 1 | Completion is an exception |
| done_cause | output | 6 | Exception cause |
| done_tval | output | XLEN | Exception value |

## Verification
There are two timing patterns. Register-only operations, misaligned accesses and illegal instructions produce `done_valid` on the clock edge that accepts them, so the bench reads the record at the falling edge right after issue. A memory operation shows its request during the first cycle after acceptance. The bench then holds the response back for a chosen number of cycles, and during that wait it requires `done_valid` to stay low and `busy` to stay high. The completion and the pointer update then show up together at the falling edge after the response edge. A behavioural pointer model and a push-down queue are compared against `ssp_value` at every falling edge.

// File: rtl/sstk_pkg.sv
package sstk_pkg;

  typedef enum logic [2:0] {
    K_ILLEGAL,
    K_ZERO,
    K_RDP,
    K_PUSH,
    K_POP,
    K_SWAPW,
    K_SWAPD
  } kind_e;

  localparam logic [5:0] CAUSE_ILLEGAL   = 6'd2;
  localparam logic [5:0] CAUSE_ST_ACCESS = 6'd7;
  localparam logic [5:0] CAUSE_SW_CHECK  = 6'd18;
  localparam int unsigned SS_FAULT_CODE  = 3;

  // address of the slot a push writes
  function automatic logic [63:0] ss_push_addr(input logic [63:0] ptr, input int unsigned nbytes);
    return ptr - 64'(nbytes);
  endfunction

  // pointer after a successful pop
  function automatic logic [63:0] ss_pop_addr(input logic [63:0] ptr, input int unsigned nbytes);
    return ptr + 64'(nbytes);
  endfunction

  // natural alignment test for a size code (log2 bytes)
  function automatic logic ss_aligned(input logic [63:0] addr, input logic [1:0] size_log2);
    logic [3:0] m;
    m = (4'd1 << size_log2) - 4'd1;
    return (addr[2:0] & m[2:0]) == 3'd0;
  endfunction

  function automatic logic [63:0] sext_word(input logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

endpackage

// File: rtl/sstk_decode.sv
module sstk_decode
  import sstk_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] instr,
  input  logic        sse_en,
  output kind_e       kind,
  output logic [4:0]  rd_idx
);

  localparam bit HAS_DWORD = (XLEN == 64);

  logic        is_comp;
  logic [15:0] ci;
  logic [4:0]  f_rd, f_rs1, f_rs2;
  logic        c_mop, mop_r, mop_rr, r28, rr7, swap_w, swap_d;

  assign is_comp = (instr[1:0] != 2'b11);
  assign ci      = instr[15:0];
  assign f_rd    = instr[11:7];
  assign f_rs1   = instr[19:15];
  assign f_rs2   = instr[24:20];

  assign c_mop  = is_comp && ((ci & 16'hF8FF) == 16'h6081);
  assign mop_r  = !is_comp && ((instr & 32'hB3C0707F) == 32'h81C04073);
  assign mop_rr = !is_comp && ((instr & 32'hB200707F) == 32'h82004073);
  assign r28    = (instr & 32'hFFF0707F) == 32'hCDC04073;
  assign rr7    = (instr & 32'hFE00707F) == 32'hCE004073;
  assign swap_w = !is_comp && ((instr & 32'hF800707F) == 32'h4800202F);
  assign swap_d = !is_comp && ((instr & 32'hF800707F) == 32'h4800302F);

  always_comb begin
    kind   = K_ILLEGAL;
    rd_idx = 5'd0;
    if (c_mop) begin
      if (sse_en && ci == 16'h6081)      kind = K_PUSH;
      else if (sse_en && ci == 16'h6281) kind = K_POP;
      else                               kind = K_ZERO;
    end else if (mop_r) begin
      rd_idx = f_rd;
      kind   = K_ZERO;
      if (sse_en && r28) begin
        if (f_rd == 5'd0 && (f_rs1 == 5'd1 || f_rs1 == 5'd5)) begin
          kind   = K_POP;
          rd_idx = 5'd0;
        end else if (f_rs1 == 5'd0 && f_rd != 5'd0) begin
          kind = K_RDP;
        end
      end
    end else if (mop_rr) begin
      rd_idx = f_rd;
      kind   = K_ZERO;
      if (sse_en && rr7 && f_rd == 5'd0 && f_rs1 == 5'd0 &&
          (f_rs2 == 5'd1 || f_rs2 == 5'd5)) begin
        kind = K_PUSH;
      end
    end else if (swap_w) begin
      rd_idx = f_rd;
      kind   = sse_en ? K_SWAPW : K_ILLEGAL;
    end else if (swap_d && HAS_DWORD) begin
      rd_idx = f_rd;
      kind   = sse_en ? K_SWAPD : K_ILLEGAL;
    end
  end

endmodule

// File: rtl/sstk_ptr_reg.sv
module sstk_ptr_reg #(
  parameter int               XLEN      = 64,
  parameter logic [XLEN-1:0]  SSP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            commit_en,
  input  logic [XLEN-1:0] commit_data,
  output logic [XLEN-1:0] ssp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ssp <= SSP_RESET;
    else if (commit_en) ssp <= commit_data;
    else if (wr_en)     ssp <= wr_data;
  end

endmodule

// File: rtl/sstk_ctrl.sv
module sstk_ctrl
  import sstk_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  kind_e           kind,
  input  logic [4:0]      rd_idx,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_data,
  input  logic [XLEN-1:0] rs2_data,
  input  logic [XLEN-1:0] ssp,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_err,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  output logic            busy,
  output logic            mem_req_valid,
  output logic            mem_req_write,
  output logic            mem_req_swap,
  output logic [1:0]      mem_req_size,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  output logic            done_valid,
  output logic            done_rd_we,
  output logic [4:0]      done_rd_idx,
  output logic [XLEN-1:0] done_rd_data,
  output logic            done_exc,
  output logic [5:0]      done_cause,
  output logic [XLEN-1:0] done_tval,
  output logic            commit_en,
  output logic [XLEN-1:0] commit_data,
  output logic            misalign_evt,
  output logic            mismatch_evt
);

  localparam int unsigned NB      = XLEN / 8;
  localparam logic [1:0]  PTR_SZ  = 2'($clog2(NB));

  typedef enum logic {S_IDLE, S_WAIT} state_e;

  state_e          state;
  kind_e           ctx_kind;
  logic [4:0]      ctx_rd;
  logic [XLEN-1:0] ctx_link;

  logic            accept, is_mem, aligned, rsp_take, link_match;
  logic [1:0]      acc_size;
  logic [63:0]     acc_addr64, ssp64;
  logic [XLEN-1:0] acc_addr;
  logic [63:0]     swap_res64;

  assign busy   = (state == S_WAIT);
  assign accept = issue_valid && (state == S_IDLE);
  assign ssp64  = 64'(ssp);
  assign is_mem = (kind == K_PUSH) || (kind == K_POP) ||
                  (kind == K_SWAPW) || (kind == K_SWAPD);

  always_comb begin
    acc_size   = PTR_SZ;
    acc_addr64 = ssp64;
    case (kind)
      K_PUSH:  acc_addr64 = ss_push_addr(ssp64, NB);
      K_SWAPW: begin acc_addr64 = 64'(rs1_data); acc_size = 2'd2; end
      K_SWAPD: begin acc_addr64 = 64'(rs1_data); acc_size = 2'd3; end
      default: ;
    endcase
  end

  assign acc_addr     = acc_addr64[XLEN-1:0];
  assign aligned      = ss_aligned(acc_addr64, acc_size);
  assign misalign_evt = accept && is_mem && !aligned;

  assign rsp_take     = busy && mem_rsp_valid;
  assign link_match   = (mem_rsp_rdata == ctx_link);
  assign mismatch_evt = rsp_take && !mem_rsp_err && (ctx_kind == K_POP) && !link_match;
  assign commit_en    = rsp_take && !mem_rsp_err &&
                        ((ctx_kind == K_PUSH) || ((ctx_kind == K_POP) && link_match));
  assign commit_data  = (ctx_kind == K_PUSH) ? mem_req_addr
                        : ss_pop_addr(64'(mem_req_addr), NB)[XLEN-1:0];
  assign swap_res64   = (ctx_kind == K_SWAPW) ? sext_word(64'(mem_rsp_rdata))
                                              : 64'(mem_rsp_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      ctx_kind      <= K_ZERO;
      ctx_rd        <= '0;
      ctx_link      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_swap  <= 1'b0;
      mem_req_size  <= '0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      done_valid    <= 1'b0;
      done_rd_we    <= 1'b0;
      done_rd_idx   <= '0;
      done_rd_data  <= '0;
      done_exc      <= 1'b0;
      done_cause    <= '0;
      done_tval     <= '0;
    end else begin
      done_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      if (accept) begin
        if (is_mem && aligned) begin
          state         <= S_WAIT;
          ctx_kind      <= kind;
          ctx_rd        <= rd_idx;
          ctx_link      <= rs1_data;
          mem_req_valid <= 1'b1;
          mem_req_write <= (kind != K_POP);
          mem_req_swap  <= (kind == K_SWAPW) || (kind == K_SWAPD);
          mem_req_size  <= acc_size;
          mem_req_addr  <= acc_addr;
          mem_req_wdata <= rs2_data;
        end else begin
          done_valid   <= 1'b1;
          done_rd_idx  <= rd_idx;
          done_rd_we   <= 1'b0;
          done_rd_data <= '0;
          done_exc     <= 1'b0;
          done_cause   <= '0;
          done_tval    <= '0;
          if (is_mem) begin
            done_exc   <= 1'b1;
            done_cause <= CAUSE_ST_ACCESS;
            done_tval  <= acc_addr;
          end else if (kind == K_ILLEGAL) begin
            done_exc   <= 1'b1;
            done_cause <= CAUSE_ILLEGAL;
            done_tval  <= XLEN'(instr);
          end else if (kind == K_RDP) begin
            done_rd_we   <= 1'b1;
            done_rd_data <= ssp;
          end else begin
            done_rd_we <= (rd_idx != 5'd0);
          end
        end
      end else if (rsp_take) begin
        state        <= S_IDLE;
        done_valid   <= 1'b1;
        done_rd_idx  <= ctx_rd;
        done_rd_we   <= 1'b0;
        done_rd_data <= '0;
        done_exc     <= 1'b0;
        done_cause   <= '0;
        done_tval    <= '0;
        if (mem_rsp_err) begin
          done_exc   <= 1'b1;
          done_cause <= CAUSE_ST_ACCESS;
          done_tval  <= mem_req_addr;
        end else if (mismatch_evt) begin
          done_exc   <= 1'b1;
          done_cause <= CAUSE_SW_CHECK;
          done_tval  <= XLEN'(SS_FAULT_CODE);
        end else if ((ctx_kind == K_SWAPW) || (ctx_kind == K_SWAPD)) begin
          done_rd_we   <= (ctx_rd != 5'd0);
          done_rd_data <= swap_res64[XLEN-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/sstk_exec_unit.sv
module sstk_exec_unit
  import sstk_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] SSP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sse_en,
  input  logic            issue_valid,
  input  logic [31:0]     issue_instr,
  input  logic [XLEN-1:0] rs1_data,
  input  logic [XLEN-1:0] rs2_data,
  output logic            busy,
  input  logic            ssp_wr_en,
  input  logic [XLEN-1:0] ssp_wr_data,
  output logic [XLEN-1:0] ssp_value,
  output logic            mem_req_valid,
  output logic            mem_req_write,
  output logic            mem_req_swap,
  output logic [1:0]      mem_req_size,
  output logic            mem_req_ss_tag,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_err,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  output logic            done_valid,
  output logic            done_rd_we,
  output logic [4:0]      done_rd_idx,
  output logic [XLEN-1:0] done_rd_data,
  output logic            done_exc,
  output logic [5:0]      done_cause,
  output logic [XLEN-1:0] done_tval
);

  kind_e           dec_kind;
  logic [4:0]      dec_rd;
  logic            commit_en;
  logic [XLEN-1:0] commit_data;
  logic            misalign_evt;
  logic            mismatch_evt;
  logic            ptr_wr_ok;

  assign ptr_wr_ok      = ssp_wr_en && !busy;
  assign mem_req_ss_tag = mem_req_valid;

  sstk_decode #(.XLEN(XLEN)) dec_i (
    .instr  (issue_instr),
    .sse_en (sse_en),
    .kind   (dec_kind),
    .rd_idx (dec_rd)
  );

  sstk_ptr_reg #(.XLEN(XLEN), .SSP_RESET(SSP_RESET)) ptr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (ptr_wr_ok),
    .wr_data     (ssp_wr_data),
    .commit_en   (commit_en),
    .commit_data (commit_data),
    .ssp         (ssp_value)
  );

  sstk_ctrl #(.XLEN(XLEN)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .kind          (dec_kind),
    .rd_idx        (dec_rd),
    .instr         (issue_instr),
    .rs1_data      (rs1_data),
    .rs2_data      (rs2_data),
    .ssp           (ssp_value),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .mem_rsp_rdata (mem_rsp_rdata),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_swap  (mem_req_swap),
    .mem_req_size  (mem_req_size),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .done_valid    (done_valid),
    .done_rd_we    (done_rd_we),
    .done_rd_idx   (done_rd_idx),
    .done_rd_data  (done_rd_data),
    .done_exc      (done_exc),
    .done_cause    (done_cause),
    .done_tval     (done_tval),
    .commit_en     (commit_en),
    .commit_data   (commit_data),
    .misalign_evt  (misalign_evt),
    .mismatch_evt  (mismatch_evt)
  );

endmodule

// File: rtl/sstk_exec_unit_chk.sv
module sstk_exec_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic            busy,
  input logic [XLEN-1:0] ssp_value,
  input logic            mem_req_valid,
  input logic            mem_req_ss_tag,
  input logic            done_valid,
  input logic            done_exc,
  input logic            done_rd_we,
  input logic [5:0]      done_cause,
  input logic            misalign_evt,
  input logic            mismatch_evt
);

  // R13
  ss_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_ss_tag);

  // R13
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_exc && $past(busy)) |-> $stable(ssp_value));

  // R3
  commit_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$stable(ssp_value)) |-> (done_valid && !done_exc));

  // R6
  misalign_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_evt |=> (done_valid && done_exc && done_cause == 6'd7));

  // R5
  mismatch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> (done_valid && done_exc && done_cause == 6'd18));

  // R12
  busy_from_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(issue_valid));

  // R11
  exc_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_exc) |-> !done_rd_we);

endmodule

bind sstk_exec_unit sstk_exec_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .issue_valid    (issue_valid),
  .busy           (busy),
  .ssp_value      (ssp_value),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ss_tag (mem_req_ss_tag),
  .done_valid     (done_valid),
  .done_exc       (done_exc),
  .done_rd_we     (done_rd_we),
  .done_cause     (done_cause),
  .misalign_evt   (misalign_evt),
  .mismatch_evt   (mismatch_evt)
);

// File: tb/sstk_exec_unit_tb_top.sv
module sstk_exec_unit_tb_top;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sse_en = 1'b0;
  logic            issue_valid = 1'b0;
  logic [31:0]     issue_instr = '0;
  logic [XLEN-1:0] rs1_data = '0, rs2_data = '0;
  logic            busy;
  logic            ssp_wr_en = 1'b0;
  logic [XLEN-1:0] ssp_wr_data = '0;
  logic [XLEN-1:0] ssp_value;
  logic            mem_req_valid, mem_req_write, mem_req_swap, mem_req_ss_tag;
  logic [1:0]      mem_req_size;
  logic [XLEN-1:0] mem_req_addr, mem_req_wdata;
  logic            mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [XLEN-1:0] mem_rsp_rdata = '0;
  logic            done_valid, done_rd_we, done_exc;
  logic [4:0]      done_rd_idx;
  logic [XLEN-1:0] done_rd_data, done_tval;
  logic [5:0]      done_cause;

  int nvec = 0;
  int nfail = 0;
  logic [63:0] model_ssp = 64'h0;
  logic [63:0] stk[$];

  always #4 clk = ~clk;

  sstk_exec_unit #(.XLEN(XLEN)) dut_i (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle; the pointer is compared with the model at every falling edge
  task automatic tick();
    @(negedge clk);
    chk("R2", "ssp_value", ssp_value, model_ssp);
  endtask

  function automatic logic [31:0] enc_mop_r(input logic [4:0] n, input logic [4:0] rd, input logic [4:0] rs1);
    return 32'h81C04073 | (32'(n[4]) << 30) | (32'(n[3:2]) << 26) | (32'(n[1:0]) << 20)
           | (32'(rs1) << 15) | (32'(rd) << 7);
  endfunction

  function automatic logic [31:0] enc_mop_rr(input logic [2:0] n, input logic [4:0] rd,
                                             input logic [4:0] rs1, input logic [4:0] rs2);
    return 32'h82004073 | (32'(n[2]) << 30) | (32'(n[1:0]) << 26) | (32'(rs2) << 20)
           | (32'(rs1) << 15) | (32'(rd) << 7);
  endfunction

  function automatic logic [31:0] enc_swap(input bit dw, input logic [4:0] rd,
                                           input logic [4:0] rs1, input logic [4:0] rs2);
    return 32'h4800202F | (32'(dw) << 12) | (32'(rs2) << 20) | (32'(rs1) << 15) | (32'(rd) << 7);
  endfunction

  task automatic set_ptr(input logic [63:0] v);
    ssp_wr_en = 1'b1; ssp_wr_data = v; model_ssp = v;
    tick();
    ssp_wr_en = 1'b0;
  endtask

  // operation that completes without memory: record due one edge after issue (R14)
  task automatic run_now(input logic [31:0] ins, input logic [63:0] r1, input logic [63:0] r2, input string req);
    issue_instr = ins; rs1_data = r1; rs2_data = r2; issue_valid = 1'b1;
    tick();
    issue_valid = 1'b0;
    chk(req, "done_valid", 64'(done_valid), 64'd1);
    chk(req, "no mem_req", 64'(mem_req_valid), 64'd0);
    chk("R14", "busy", 64'(busy), 64'd0);
  endtask

  task automatic run_mem(input logic [31:0] ins, input logic [63:0] r1, input logic [63:0] r2,
                         input int lat, input logic [63:0] rdata, input bit err,
                         input logic [63:0] eaddr, input bit ewrite, input bit eswap,
                         input logic [1:0] esize, input logic [63:0] ssp_after,
                         input bit disturb, input string req);
    issue_instr = ins; rs1_data = r1; rs2_data = r2; issue_valid = 1'b1;
    tick();
    issue_valid = 1'b0;
    chk(req, "mem_req_valid", 64'(mem_req_valid), 64'd1);
    chk("R13", "mem_req_ss_tag", 64'(mem_req_ss_tag), 64'd1);
    chk(req, "mem_req_addr", mem_req_addr, eaddr);
    chk(req, "mem_req_write", 64'(mem_req_write), 64'(ewrite));
    chk(req, "mem_req_swap", 64'(mem_req_swap), 64'(eswap));
    chk(req, "mem_req_size", 64'(mem_req_size), 64'(esize));
    if (ewrite) chk(req, "mem_req_wdata", mem_req_wdata, r2);
    chk("R12", "busy", 64'(busy), 64'd1);
    for (int i = 0; i < lat; i++) begin
      if (disturb) begin
        issue_valid = 1'b1; issue_instr = enc_mop_r(5'd28, 5'd6, 5'd0);
        ssp_wr_en = 1'b1; ssp_wr_data = 64'hDEAD_0000;
      end
      tick();
      issue_valid = 1'b0; ssp_wr_en = 1'b0;
      chk("R13", "mem_req pulse", 64'(mem_req_valid), 64'd0);
      chk("R14", "done early", 64'(done_valid), 64'd0);
      chk("R12", "busy held", 64'(busy), 64'd1);
    end
    mem_rsp_valid = 1'b1; mem_rsp_rdata = rdata; mem_rsp_err = err;
    model_ssp = ssp_after;
    tick();
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    chk("R14", "done_valid", 64'(done_valid), 64'd1);
    chk("R12", "busy released", 64'(busy), 64'd0);
  endtask

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1", "ssp reset", ssp_value, 64'h0);
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done_valid", 64'(done_valid), 64'd0);
    chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    tick();

    // R2 pointer write while idle
    set_ptr(64'h1000);
    sse_en = 1'b1;

    // R3 push x1, 32-bit form, latency 2
    stk.push_front(64'hA1A1_0000_0000_0001);
    run_mem(enc_mop_rr(3'd7, 5'd0, 5'd0, 5'd1), 64'h0, stk[0], 2, 64'h0, 1'b0,
            64'hFF8, 1'b1, 1'b0, 2'd3, 64'hFF8, 1'b0, "R3");
    chk("R3", "push no exc", 64'(done_exc), 64'd0);
    chk("R3", "push no rd write", 64'(done_rd_we), 64'd0);

    // R3 compressed push, response in the request cycle
    stk.push_front(64'hB2B2_0000_0000_0002);
    run_mem(32'h0000_6081, 64'h0, stk[0], 0, 64'h0, 1'b0,
            64'hFF0, 1'b1, 1'b0, 2'd3, 64'hFF0, 1'b0, "R3");
    chk("R3", "c.push no exc", 64'(done_exc), 64'd0);

    // R8 read pointer
    run_now(enc_mop_r(5'd28, 5'd7, 5'd0), 64'h0, 64'h0, "R8");
    chk("R8", "rd_we", 64'(done_rd_we), 64'd1);
    chk("R8", "rd_idx", 64'(done_rd_idx), 64'd7);
    chk("R8", "rd_data", done_rd_data, 64'hFF0);

    // R4 pop-and-check x5, 32-bit form, match
    run_mem(enc_mop_r(5'd28, 5'd0, 5'd5), stk[0], 64'h0, 1, stk[0], 1'b0,
            64'hFF0, 1'b0, 1'b0, 2'd3, 64'hFF8, 1'b0, "R4");
    chk("R4", "pop no exc", 64'(done_exc), 64'd0);
    void'(stk.pop_front());

    // R5 compressed pop with a wrong link value
    run_mem(32'h0000_6281, 64'h1234, 64'h0, 1, stk[0], 1'b0,
            64'hFF8, 1'b0, 1'b0, 2'd3, 64'hFF8, 1'b0, "R5");
    chk("R5", "exc", 64'(done_exc), 64'd1);
    chk("R5", "cause", 64'(done_cause), 64'd18);
    chk("R5", "tval", done_tval, 64'd3);

    // R7 memory error on pop
    run_mem(32'h0000_6281, stk[0], 64'h0, 2, stk[0], 1'b1,
            64'hFF8, 1'b0, 1'b0, 2'd3, 64'hFF8, 1'b0, "R7");
    chk("R7", "exc", 64'(done_exc), 64'd1);
    chk("R7", "cause", 64'(done_cause), 64'd7);
    chk("R7", "tval", done_tval, 64'hFF8);

    // R12 issue and pointer writes ignored while busy
    run_mem(enc_mop_rr(3'd7, 5'd0, 5'd0, 5'd5), 64'h0, 64'hC3, 3, 64'h0, 1'b0,
            64'hFF0, 1'b1, 1'b0, 2'd3, 64'hFF0, 1'b1, "R12");
    tick();
    chk("R12", "no second completion", 64'(done_valid), 64'd0);
    chk("R12", "no second request", 64'(mem_req_valid), 64'd0);

    // R6 misaligned push
    set_ptr(64'h1004);
    run_now(32'h0000_6081, 64'h0, 64'h77, "R6");
    chk("R6", "exc", 64'(done_exc), 64'd1);
    chk("R6", "cause", 64'(done_cause), 64'd7);
    chk("R6", "tval", done_tval, 64'hFFC);

    // R9 shadow stacks disabled
    sse_en = 1'b0;
    run_now(enc_mop_r(5'd28, 5'd9, 5'd0), 64'h0, 64'h0, "R9");
    chk("R9", "rd_we", 64'(done_rd_we), 64'd1);
    chk("R9", "rd_data zero", done_rd_data, 64'h0);
    run_now(enc_mop_rr(3'd7, 5'd0, 5'd0, 5'd1), 64'h0, 64'h55, "R9");
    chk("R9", "push as mop no exc", 64'(done_exc), 64'd0);
    chk("R9", "push as mop rd_we", 64'(done_rd_we), 64'd0);
    run_now(32'h0000_6081, 64'h0, 64'h55, "R9");
    chk("R9", "c.mop no write", 64'(done_rd_we), 64'd0);

    // R11 swap while disabled
    run_now(enc_swap(1'b0, 5'd10, 5'd11, 5'd12), 64'h3000, 64'h1, "R11");
    chk("R11", "exc", 64'(done_exc), 64'd1);
    chk("R11", "cause", 64'(done_cause), 64'd2);
    chk("R11", "tval", done_tval, 64'(enc_swap(1'b0, 5'd10, 5'd11, 5'd12)));

    // R9 non-shadow one-source mop while enabled
    sse_en = 1'b1;
    run_now(enc_mop_r(5'd28, 5'd3, 5'd2), 64'h0, 64'h0, "R9");
    chk("R9", "mop rd_we", 64'(done_rd_we), 64'd1);
    chk("R9", "mop rd_data", done_rd_data, 64'h0);

    // R10 word swap, sign-extended result
    set_ptr(64'h2000);
    run_mem(enc_swap(1'b0, 5'd10, 5'd11, 5'd12), 64'h3004, 64'h55, 1, 64'h0000_0000_8000_0001, 1'b0,
            64'h3004, 1'b1, 1'b1, 2'd2, 64'h2000, 1'b0, "R10");
    chk("R10", "rd_we", 64'(done_rd_we), 64'd1);
    chk("R10", "rd_data", done_rd_data, 64'hFFFF_FFFF_8000_0001);

    // R6 misaligned doubleword swap
    run_now(enc_swap(1'b1, 5'd10, 5'd11, 5'd12), 64'h3004, 64'h1, "R6");
    chk("R6", "swap cause", 64'(done_cause), 64'd7);
    chk("R6", "swap tval", done_tval, 64'h3004);

    // R10 doubleword swap
    run_mem(enc_swap(1'b1, 5'd13, 5'd11, 5'd12), 64'h3008, 64'h99, 2, 64'h1122_3344_5566_7788, 1'b0,
            64'h3008, 1'b1, 1'b1, 2'd3, 64'h2000, 1'b0, "R10");
    chk("R10", "rd_idx", 64'(done_rd_idx), 64'd13);
    chk("R10", "rd_data", done_rd_data, 64'h1122_3344_5566_7788);

    // R11 unrecognised instruction
    run_now(32'h0000_0013, 64'h0, 64'h0, "R11");
    chk("R11", "cause", 64'(done_cause), 64'd2);
    chk("R11", "no write", 64'(done_rd_we), 64'd0);

    tick();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule